// File: doc/BRIEF.md
# SD card SPI-mode responder

This block is the card side of a serial peripheral bus link to an SD memory card, running in the card's SPI command mode. A host drives the serial clock, the command data line and a chip-select line. The block returns bytes on its serial data output. It gathers six-byte command frames and recognises five commands: go-idle, application prefix, initialise, operating-conditions read and single-block read. For each of these it sends the matching response after a one-byte gap.

Initialisation has two steps. The card stays in the idle state until an application-prefix command is followed by the initialise command. Only after that does a block read return data. The capacity input picks between two modes. In high-capacity mode the read argument is a block number and the OCR capacity flag is reported. In standard mode the read argument is a byte address and the flag is clear. Data comes from a fixed on-chip image. Addresses beyond the image read as zero.

The serial pins are oversampled by the system clock through synchronisers. The SPI clock must therefore run at no more than one eighth of the system clock.

Top module: `sd_spi_responder`

## Requirements
- R1: The card is selected when `sel_line` is at its active level, which is low by default and set by the `CS_ACTIVE_LOW` parameter. While the card is deselected, `miso` is held at 1.
- R2: Transfers use SPI mode 0. `mosi` is sampled on the rising `sck` edge, `miso` changes on the falling edge, and bytes go MSB first. With no response pending, every byte sent is 0xFF. A byte received while idle whose top two bits are not 01 is ignored.
- R3: A command frame is six bytes: 0x40 OR a 6-bit index, a 32-bit argument sent most significant byte first, and a CRC byte that is not checked. The byte clocked out right after the frame is a 0xFF gap, and the response starts on the byte after it.
- R4: An R1 byte carries the idle flag in bit 0. This flag is 1 until initialisation completes. Command 0 answers 0x01 and returns the card to the not-ready state.
- R5: Command 55 followed directly by command 41 makes the card ready, and that command 41 answers 0x00. Command 41 without the prefix answers 0x05 and leaves the card not ready.
- R6: Command 58 answers five bytes: R1, then 0x40 when `hc_mode` is 1 or 0x00 when it is 0, then 0x00 0x00 0x00.
- R7: When the card is ready, command 17 answers 0x00, then a 0xFE start token, then 512 data bytes, then 0xFF 0xFF. When the card is not ready it answers only 0x01, with no token and no data.
- R8: The first data byte address is the argument times 512 when `hc_mode` is 1, and the argument itself when `hc_mode` is 0. The byte at address a is (a mod 256) XOR ((a div 256) mod 256) XOR 0x5A when a < `IMG_BYTES`, and 0x00 otherwise or when `IMG_PRESENT` is 0.
- R9: Deselecting the card aborts a response in progress and clears the partial byte. After the card is selected again, the next bytes out are 0xFF. Readiness is kept.
- R10: A command with any other index answers R1 with the illegal-command flag in bit 2 set: 0x05 before initialisation and 0x04 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are oversampled by it |
| rst_n | input | 1 | Synchronous active-low reset |
| hc_mode | input | 1 | 1 = high-capacity (block addressed), 0 = standard (byte addressed) |
| sel_line | input | 1 | Chip select line, polarity set by `CS_ACTIVE_LOW` |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Command data from the host |
| miso | output | 1 | Response data to the host |

## Verification
The command path is driven with these inputs:
- a junk byte while idle, which shows that only a 01-prefixed byte opens a frame;
- initialise without its prefix, then with it, which shows the two-step readiness rule;
- an unknown index, which isolates the illegal flag;
- the OCR read in both capacity modes.

Full block reads are run three ways:
- a high-capacity block inside the image, which shows the times-512 scaling;
- a standard-mode byte address that crosses the image end, which shows byte scaling and zero fill within one block;
- a high-capacity block past the end, which reads all zeros.

A read aborted by deselect, followed by a go-idle, shows that the bit counter and response state are cleared while readiness survives until command 0.

// File: rtl/sd_spi_pkg.sv
// Package: shared types, byte codes and the image content function for the
// SD SPI-mode responder. Assumes 8-bit serial bytes and 6-bit command codes.
package sd_spi_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_RESP = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        RK_R1   = 2'd0,
        RK_R3   = 2'd1,
        RK_READ = 2'd2
    } resp_kind_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] START_TOKEN = 8'hFE;
    localparam logic [7:0] OCR_HC_FLAG = 8'h40;

    localparam logic [5:0] CMD_GO_IDLE = 6'd0;
    localparam logic [5:0] CMD_RD_ONE  = 6'd17;
    localparam logic [5:0] CMD_INIT    = 6'd41;
    localparam logic [5:0] CMD_APP     = 6'd55;
    localparam logic [5:0] CMD_OCR     = 6'd58;

    // Content of the fixed on-chip image at byte address a.
    function automatic logic [7:0] img_pattern(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

endpackage

// File: rtl/sd_sync_bit.sv
// Module: multi-stage flop synchroniser for one asynchronous input bit.
// Assumes STAGES >= 2; the output resets to RST_VAL.
module sd_sync_bit #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/sd_spi_link.sv
// Module: SPI mode-0 bit layer. It synchronises sck, mosi and the select line,
// gathers MSB-first bytes on rising sck, and shifts out tx_next on falling sck
// at each byte boundary. Deselect clears the bit counter and both shifters.
// Assumes sck is slower than clk/8.
module sd_spi_link #(
    parameter bit CS_ACTIVE_LOW = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_line,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] tx_next,
    output logic       sel,
    output logic       byte_vld,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic s_sck, s_mosi, sck_d;
    logic sck_rise, sck_fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr, tx_sr;

    sd_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d(sck), .q(s_sck));
    sd_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d(mosi), .q(s_mosi));
    sd_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d(sel_line ^ CS_ACTIVE_LOW), .q(sel));

    assign sck_rise = s_sck & ~sck_d;
    assign sck_fall = ~s_sck & sck_d;

    // Track the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= s_sck;
    end

    // Receive: count bits and assemble bytes on rising sck.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= 3'd0;
            rx_sr    <= 8'h00;
            rx_byte  <= 8'h00;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (!sel) begin
                bit_cnt <= 3'd0;
                rx_sr   <= 8'h00;
            end else if (sck_rise) begin
                rx_sr   <= {rx_sr[6:0], s_mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_vld <= 1'b1;
                    rx_byte  <= {rx_sr[6:0], s_mosi};
                end
            end
        end
    end

    // Transmit: load the next byte at a boundary, else shift, on falling sck.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            tx_sr <= sd_spi_pkg::FILL_BYTE;
        end else if (sck_fall) begin
            if (bit_cnt == 3'd0) tx_sr <= tx_next;
            else                 tx_sr <= {tx_sr[6:0], 1'b1};
        end
    end

    assign miso = sel ? tx_sr[7] : 1'b1;
endmodule

// File: rtl/sd_block_source.sv
// Module: maps the read argument and offset within the block to a byte
// address, scaling by the block size in high-capacity mode, and returns the
// image byte. Addresses past the image, or an absent image, read as zero.
module sd_block_source #(
    parameter int BLK_BYTES   = 512,
    parameter int IMG_BYTES   = 2048,
    parameter bit IMG_PRESENT = 1'b1,
    parameter int OFF_W       = 10
) (
    input  logic             hc_mode,
    input  logic [31:0]      cmd_arg,
    input  logic [OFF_W-1:0] blk_offset,
    output logic [7:0]       blk_data
);
    localparam int BLK_SHIFT = $clog2(BLK_BYTES);

    logic [31:0] base_addr, byte_addr;

    // Select block or byte addressing and add the offset within the block.
    always_comb begin
        base_addr = hc_mode ? (cmd_arg << BLK_SHIFT) : cmd_arg;
        byte_addr = base_addr + 32'(blk_offset);
    end

    generate
        if (IMG_PRESENT) begin : g_image
            // Pattern-backed image with zero fill past its end.
            always_comb begin
                if (byte_addr < 32'(IMG_BYTES)) blk_data = sd_spi_pkg::img_pattern(byte_addr);
                else                            blk_data = 8'h00;
            end
        end else begin : g_no_image
            assign blk_data = 8'h00;
        end
    endgenerate
endmodule

// File: rtl/sd_cmd_engine.sv
// Module: command frame assembler, decoder and response sequencer. It keeps
// the ready and app-prefix flags and emits the next byte to transmit, with one
// 0xFF gap before each response. Deselect returns it to idle; readiness stays.
module sd_cmd_engine #(
    parameter int BLK_BYTES = 512,
    parameter int POS_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             byte_vld,
    input  logic [7:0]       rx_byte,
    input  logic             hc_mode,
    input  logic [7:0]       blk_data,
    output logic [7:0]       tx_next,
    output logic [31:0]      cmd_arg,
    output logic [POS_W-1:0] blk_offset,
    output logic [5:0]       cmd_code,
    output logic             card_ready,
    output logic             resp_on,
    output logic             resp_is_read
);
    import sd_spi_pkg::*;

    localparam int READ_LAST = BLK_BYTES + 3;

    phase_t           phase;
    resp_kind_t       kind, dec_kind;
    logic [2:0]       frame_cnt;
    logic [POS_W-1:0] pos, last_pos, dec_last;
    logic [7:0]       r1_val, dec_r1, resp_byte;
    logic             app_pend, dec_ready, dec_app, dec_illegal;
    logic             frame_done;

    assign frame_done = byte_vld && sel && phase == PH_CMD && frame_cnt == 3'd5;

    // Decode the captured command into flag updates and response shape.
    always_comb begin
        dec_ready   = card_ready;
        dec_app     = 1'b0;
        dec_kind    = RK_R1;
        dec_illegal = 1'b0;
        case (cmd_code)
            CMD_GO_IDLE: dec_ready = 1'b0;
            CMD_APP:     dec_app = 1'b1;
            CMD_INIT:    if (app_pend) dec_ready = 1'b1; else dec_illegal = 1'b1;
            CMD_OCR:     dec_kind = RK_R3;
            CMD_RD_ONE:  if (card_ready) dec_kind = RK_READ;
            default:     dec_illegal = 1'b1;
        endcase
        dec_r1 = {5'b0, dec_illegal, 1'b0, ~dec_ready};
        case (dec_kind)
            RK_R3:   dec_last = POS_W'(4);
            RK_READ: dec_last = POS_W'(READ_LAST);
            default: dec_last = '0;
        endcase
    end

    // Pick the response byte for the current position.
    always_comb begin
        blk_offset = pos - POS_W'(2);
        resp_byte  = FILL_BYTE;
        case (kind)
            RK_R1: resp_byte = r1_val;
            RK_R3: begin
                if (pos == '0)              resp_byte = r1_val;
                else if (pos == POS_W'(1))  resp_byte = hc_mode ? OCR_HC_FLAG : 8'h00;
                else                        resp_byte = 8'h00;
            end
            RK_READ: begin
                if (pos == '0)                          resp_byte = r1_val;
                else if (pos == POS_W'(1))              resp_byte = START_TOKEN;
                else if (pos <= POS_W'(BLK_BYTES + 1))  resp_byte = blk_data;
                else                                    resp_byte = FILL_BYTE;
            end
            default: resp_byte = FILL_BYTE;
        endcase
    end

    // Phase sequencing and transmit byte selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase     <= PH_IDLE;
            frame_cnt <= 3'd0;
            pos       <= '0;
            tx_next   <= FILL_BYTE;
        end else if (byte_vld) begin
            case (phase)
                PH_IDLE: begin
                    tx_next <= FILL_BYTE;
                    if (rx_byte[7:6] == 2'b01) begin
                        phase     <= PH_CMD;
                        frame_cnt <= 3'd1;
                    end
                end
                PH_CMD: begin
                    tx_next <= FILL_BYTE;
                    if (frame_cnt == 3'd5) begin
                        phase <= PH_RESP;
                        pos   <= '0;
                    end else begin
                        frame_cnt <= frame_cnt + 3'd1;
                    end
                end
                PH_RESP: begin
                    tx_next <= resp_byte;
                    if (pos == last_pos) phase <= PH_IDLE;
                    else                 pos <= pos + POS_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Capture the command code, argument and decoded response shape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code <= 6'd0;
            cmd_arg  <= 32'd0;
            r1_val   <= 8'h01;
            kind     <= RK_R1;
            last_pos <= '0;
        end else if (byte_vld && sel) begin
            if (phase == PH_IDLE && rx_byte[7:6] == 2'b01) begin
                cmd_code <= rx_byte[5:0];
            end else if (phase == PH_CMD && frame_cnt <= 3'd4) begin
                cmd_arg <= {cmd_arg[23:0], rx_byte};
            end else if (frame_done) begin
                r1_val   <= dec_r1;
                kind     <= dec_kind;
                last_pos <= dec_last;
            end
        end
    end

    // Card readiness and application-prefix flags, updated per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_ready <= 1'b0;
            app_pend   <= 1'b0;
        end else if (frame_done) begin
            card_ready <= dec_ready;
            app_pend   <= dec_app;
        end
    end

    assign resp_on      = (phase == PH_RESP);
    assign resp_is_read = resp_on && kind == RK_READ;
endmodule

// File: rtl/sd_spi_responder.sv
// Module: top of the SD SPI-mode responder. It joins the serial link, the
// command engine and the block source. It assumes sck runs at no more than
// clk/8 and that the host follows SPI mode 0.
module sd_spi_responder #(
    parameter bit CS_ACTIVE_LOW = 1'b1,
    parameter int BLK_BYTES     = 512,
    parameter int IMG_BYTES     = 2048,
    parameter bit IMG_PRESENT   = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hc_mode,
    input  logic sel_line,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int POS_W = $clog2(BLK_BYTES + 4);

    logic             link_sel, link_byte_vld;
    logic [7:0]       link_rx_byte, eng_tx_next, src_data;
    logic [31:0]      eng_arg;
    logic [POS_W-1:0] eng_offset;
    logic [5:0]       eng_cmd_code;
    logic             eng_ready, eng_resp_on, eng_resp_read;

    sd_spi_link #(
        .CS_ACTIVE_LOW(CS_ACTIVE_LOW),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_line(sel_line),
        .sck     (sck),
        .mosi    (mosi),
        .tx_next (eng_tx_next),
        .sel     (link_sel),
        .byte_vld(link_byte_vld),
        .rx_byte (link_rx_byte),
        .miso    (miso)
    );

    sd_cmd_engine #(
        .BLK_BYTES(BLK_BYTES),
        .POS_W    (POS_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (link_sel),
        .byte_vld    (link_byte_vld),
        .rx_byte     (link_rx_byte),
        .hc_mode     (hc_mode),
        .blk_data    (src_data),
        .tx_next     (eng_tx_next),
        .cmd_arg     (eng_arg),
        .blk_offset  (eng_offset),
        .cmd_code    (eng_cmd_code),
        .card_ready  (eng_ready),
        .resp_on     (eng_resp_on),
        .resp_is_read(eng_resp_read)
    );

    sd_block_source #(
        .BLK_BYTES  (BLK_BYTES),
        .IMG_BYTES  (IMG_BYTES),
        .IMG_PRESENT(IMG_PRESENT),
        .OFF_W      (POS_W)
    ) u_source (
        .hc_mode   (hc_mode),
        .cmd_arg   (eng_arg),
        .blk_offset(eng_offset),
        .blk_data  (src_data)
    );
endmodule

// File: rtl/sd_spi_responder_chk.sv
// Module: assertion checker for the SD SPI-mode responder, bound to the top.
module sd_spi_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       byte_vld,
    input logic [7:0] tx_next,
    input logic [5:0] cmd_code,
    input logic       card_ready,
    input logic       resp_on,
    input logic       resp_is_read
);
    AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_ready) |-> cmd_code == 6'd41); // R5
    AST_READY_DROP_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_ready) |-> cmd_code == 6'd0); // R4
    AST_READ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_is_read |-> card_ready); // R7
    AST_DESEL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!resp_on && tx_next == 8'hFF)); // R9
    AST_GAP_BEFORE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_on) |-> tx_next == 8'hFF); // R3
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R2
endmodule

bind sd_spi_responder sd_spi_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (link_sel),
    .byte_vld    (link_byte_vld),
    .tx_next     (eng_tx_next),
    .cmd_code    (eng_cmd_code),
    .card_ready  (eng_ready),
    .resp_on     (eng_resp_on),
    .resp_is_read(eng_resp_read)
);

// File: tb/sd_spi_responder_test.sv
// Scoreboard bench: the byte driver queues the expected MISO byte and a
// monitor on the serial clock assembles and compares what comes back.
module sd_spi_responder_test;
    localparam int HALF = 4;
    localparam int WD_CYCLES = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hc_mode = 1'b1;
    logic sel_line = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b1;
    logic miso;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    sd_spi_responder uut (
        .clk(clk), .rst_n(rst_n), .hc_mode(hc_mode),
        .sel_line(sel_line), .sck(sck), .mosi(mosi), .miso(miso));

    function automatic logic [7:0] pat(input logic [31:0] a);
        if (a < 32'd2048) return a[7:0] ^ a[15:8] ^ 8'h5A;
        return 8'h00;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: queue the expected reply, then clock one byte out MSB first.
    task automatic xbyte(input logic [7:0] tx, input logic [7:0] exp, input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        expq.push_back(e);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        xbyte(8'hFF, exp, tag);
    endtask

    task automatic cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc);
        xbyte(8'h40 | {2'b00, idx}, 8'hFF, "R2");
        xbyte(arg[31:24], 8'hFF, "R2");
        xbyte(arg[23:16], 8'hFF, "R2");
        xbyte(arg[15:8], 8'hFF, "R2");
        xbyte(arg[7:0], 8'hFF, "R2");
        xbyte(crc, 8'hFF, "R2");
        rd(8'hFF, "R3");
    endtask

    task automatic read_block(input logic [31:0] arg, input logic [31:0] base, input string tag);
        cmd(6'd17, arg, 8'hFF);
        rd(8'h00, "R7");
        rd(8'hFE, "R7");
        for (int i = 0; i < 512; i++) rd(pat(base + 32'(i)), tag);
        rd(8'hFF, "R7");
        rd(8'hFF, "R7");
        rd(8'hFF, "R2");
    endtask

    task automatic ocr(input logic [7:0] r1, input logic [7:0] flag, input string tag);
        cmd(6'd58, 32'd0, 8'hFD);
        rd(r1, tag);
        rd(flag, "R6");
        rd(8'h00, "R6");
        rd(8'h00, "R6");
        rd(8'h00, "R6");
    endtask

    // Monitor: rebuild bytes from MISO at each rising sck, and compare them.
    initial begin
        int n = 0;
        logic [7:0] sh = 8'h00;
        forever begin
            @(posedge sck or posedge sel_line);
            if (sel_line) begin
                n = 0;
            end else begin
                sh = {sh[6:0], miso};
                n++;
                if (n == 8) begin
                    n = 0;
                    if (expq.size() == 0) begin
                        total++;
                        bad++;
                        $display("FAIL R2: unexpected byte %02h, expected none", sh);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check(sh, e.exp, e.tag);
                    end
                end
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({7'd0, miso}, 8'd1, "R1 reset deselected miso");

        sel_line = 1'b0;
        repeat (8) @(negedge clk);
        rd(8'hFF, "R2");
        xbyte(8'h12, 8'hFF, "R2");
        rd(8'hFF, "R2");

        // Not ready: OCR read and block read both show the idle flag.
        hc_mode = 1'b1;
        ocr(8'h01, 8'h40, "R4");
        rd(8'hFF, "R2");
        cmd(6'd17, 32'd1, 8'hFF);
        rd(8'h01, "R7");
        rd(8'hFF, "R7");

        // Init without prefix, then an unknown index.
        cmd(6'd41, 32'h4000_0000, 8'h77);
        rd(8'h05, "R5");
        cmd(6'd8, 32'h0000_01AA, 8'h87);
        rd(8'h05, "R10");

        // Proper initialisation sequence.
        cmd(6'd55, 32'd0, 8'h65);
        rd(8'h01, "R5");
        cmd(6'd41, 32'h4000_0000, 8'h77);
        rd(8'h00, "R5");
        cmd(6'd8, 32'd0, 8'h87);
        rd(8'h04, "R10");

        ocr(8'h00, 8'h40, "R6");
        hc_mode = 1'b0;
        ocr(8'h00, 8'h00, "R6");

        hc_mode = 1'b1;
        read_block(32'd1, 32'd512, "R8 hc block 1");
        hc_mode = 1'b0;
        read_block(32'h0000_0700, 32'h0000_0700, "R8 byte addr past end");
        hc_mode = 1'b1;
        read_block(32'd4, 32'd2048, "R8 hc block beyond image");

        // Abort a read partway through a byte.
        cmd(6'd17, 32'd0, 8'hFF);
        rd(8'h00, "R7");
        rd(8'hFE, "R7");
        rd(pat(32'd0), "R8");
        rd(pat(32'd1), "R8");
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        sel_line = 1'b1;
        repeat (8) @(negedge clk);
        check({7'd0, miso}, 8'd1, "R1 deselected miso");
        sel_line = 1'b0;
        repeat (8) @(negedge clk);
        rd(8'hFF, "R9");
        rd(8'hFF, "R9");
        ocr(8'h00, 8'h40, "R9 ready kept");

        // Go-idle drops readiness.
        cmd(6'd0, 32'd0, 8'h95);
        rd(8'h01, "R4");
        ocr(8'h01, 8'h40, "R4");
        cmd(6'd17, 32'd0, 8'hFF);
        rd(8'h01, "R7");
        rd(8'hFF, "R7");

        repeat (20) @(negedge clk);
        if (expq.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2: got %0d pending bytes expected 0", expq.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule